// File: doc/BRIEF.md
# Windowed Register Index Flattener

This block turns an extended integer register number into a location in one flat physical register array, for a processor that keeps its integer registers in overlapping, circularly arranged windows. The result depends on two pieces of context supplied with the request: the current global level, which picks one of several banks of eight global registers, and the current window pointer, which picks the window that architectural registers 8 and up refer to. The extended index space covers more than the architectural registers. It also includes a small group of microcode scratch registers and two alias ranges. These alias ranges reach the window one step below and one step above the current one, so microcode can move values across a window switch.

The physical array is laid out in this order: all global banks first, then the circular window region at sixteen registers per window, then the microcode scratch registers. Window offsets are taken modulo the size of the window region, using a mask and no divider. An index past the last alias range raises an invalid flag, and the physical index then reads as zero. A small physical register array is attached behind two flatteners, one for reads and one for writes. A write lands where its flattened index points. Reads go through the same mapping, so aliasing between windows can be seen at the ports.

Top module: `regwin_flatten`

## Requirements
- R1: In each of the three register ranges (architectural at 0..31, previous-window alias at 40..71, next-window alias at 72..103), a local register number 0..7 maps to physical index local + 8*gl, whatever the window pointer.
- R2: An architectural index r in 8..31 maps to 32 + ((r - 8 + 128 - 16*cwp) mod 128).
- R3: A microcode index r in 32..39 maps to physical index r - 32 + 160, whatever gl and cwp.
- R4: An index r in 40..71 has local number r - 40. Local numbers 8..31 map as R2 with the window (cwp - 1) mod 8, so cwp 0 uses window 7.
- R5: An index r in 72..103 has local number r - 72. Local numbers 8..31 map as R2 with the window (cwp + 1) mod 8, so cwp 7 uses window 0.
- R6: An index of 104 or more sets rd_invalid_o to 1, forces rd_phys_o to 0 and forces rd_data_o to 0. Every legal index gives rd_invalid_o = 0 and rd_phys_o below 168.
- R7: When wr_en_i is high at a rising clock edge and the write index is legal, the data is stored at the write index's flattened location. It is returned from the next cycle on by any read index that flattens to that same location.
- R8: A write whose index is 104 or more changes no stored value.
- R9: After reset every physical register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the attached register array |
| rst_n | input | 1 | Asynchronous active-low reset, clears the array |
| gl_i | input | 2 | Current global level |
| cwp_i | input | 3 | Current window pointer |
| rd_idx_i | input | 7 | Extended index to flatten and read |
| rd_phys_o | output | 8 | Flattened physical index of rd_idx_i |
| rd_invalid_o | output | 1 | rd_idx_i lies beyond the last alias range |
| rd_data_o | output | 16 | Contents of the flattened read location, zero when invalid |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | 7 | Extended index to write, flattened with gl_i and cwp_i |
| wr_data_i | input | 16 | Write data |

## Verification
The bench builds the block with its default parameters: 32 architectural registers, 8 windows, 4 global levels, 8 microcode registers and 16-bit data. This makes the whole space of 4 levels × 8 pointers × 128 indices small enough to sweep completely, so every wrap of the previous and next window at pointers 0 and 7, and every illegal index, is covered. All 168 physical locations are filled through ordinary, alias and microcode indices, and the full sweep is then repeated. That pass shows that each alias reads back the value written through its partner, and that writes to illegal indices leave everything unchanged.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // Which part of the extended index space a request falls into
    typedef enum logic [2:0] {
        SEG_ARCH  = 3'd0,
        SEG_MICRO = 3'd1,
        SEG_PREV  = 3'd2,
        SEG_NEXT  = 3'd3,
        SEG_BAD   = 3'd4
    } seg_e;

    // Registers per window step and per global bank
    localparam int WIN_STRIDE = 16;
    localparam int BANK_SIZE  = 8;

endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NUM_ARCH  = 32,
    parameter int N_WIN     = 8,
    parameter int MAX_GL    = 4,
    parameter int NUM_MICRO = 8,
    parameter int GL_W      = 2,
    parameter int CWP_W     = 3,
    parameter int IDX_W     = 7,
    parameter int PHYS_W    = 8
) (
    input  logic [GL_W-1:0]   gl_i,
    input  logic [CWP_W-1:0]  cwp_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              bad_o,
    output seg_e              seg_o
);

    localparam int CIRC_W     = CWP_W + 4;
    localparam int GL_BASE    = MAX_GL * BANK_SIZE;
    localparam int MICRO_BASE = GL_BASE + N_WIN * WIN_STRIDE;

    localparam logic [IDX_W-1:0] LIM_ARCH  = IDX_W'(NUM_ARCH);
    localparam logic [IDX_W-1:0] LIM_MICRO = IDX_W'(NUM_ARCH + NUM_MICRO);
    localparam logic [IDX_W-1:0] LIM_PREV  = IDX_W'(2 * NUM_ARCH + NUM_MICRO);
    localparam logic [IDX_W-1:0] LIM_NEXT  = IDX_W'(3 * NUM_ARCH + NUM_MICRO);
    localparam logic [IDX_W-1:0] GLOB_N    = IDX_W'(BANK_SIZE);

    localparam logic [PHYS_W-1:0] GL_BASE_P    = PHYS_W'(GL_BASE);
    localparam logic [PHYS_W-1:0] MICRO_BASE_P = PHYS_W'(MICRO_BASE);

    // Three window choices: current, one below, one above.
    // The pointer add wraps in CWP_W bits; the negated window base wraps
    // in CIRC_W bits, which is the power-of-two modulo of the ring.
    logic [CWP_W-1:0]  win  [3];
    logic [CIRC_W-1:0] wneg [3];

    for (genvar k = 0; k < 3; k++) begin : g_win
        localparam int STEP = (k == 1) ? (N_WIN - 1) : ((k == 2) ? 1 : 0);
        assign win[k]  = cwp_i + CWP_W'(STEP);
        assign wneg[k] = '0 - {win[k], 4'b0000};
    end

    logic [IDX_W-1:0]  lr;
    logic [CIRC_W-1:0] wsel;
    logic [CIRC_W-1:0] circ;

    always_comb begin
        seg_o = SEG_BAD;
        lr    = '0;
        wsel  = wneg[0];
        if (idx_i < LIM_ARCH) begin
            seg_o = SEG_ARCH;
            lr    = idx_i;
        end else if (idx_i < LIM_MICRO) begin
            seg_o = SEG_MICRO;
            lr    = idx_i - LIM_ARCH;
        end else if (idx_i < LIM_PREV) begin
            seg_o = SEG_PREV;
            lr    = idx_i - LIM_MICRO;
            wsel  = wneg[1];
        end else if (idx_i < LIM_NEXT) begin
            seg_o = SEG_NEXT;
            lr    = idx_i - LIM_PREV;
            wsel  = wneg[2];
        end

        circ  = CIRC_W'(lr - GLOB_N) + wsel;
        bad_o = (seg_o == SEG_BAD);

        case (seg_o)
            SEG_BAD:   phys_o = '0;
            SEG_MICRO: phys_o = MICRO_BASE_P + PHYS_W'(lr);
            default: begin
                if (lr < GLOB_N) phys_o = PHYS_W'({gl_i, lr[2:0]});
                else             phys_o = GL_BASE_P + PHYS_W'(circ);
            end
        endcase
    end

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
    parameter int DEPTH  = 168,
    parameter int DATA_W = 16,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] cells;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i && (int'(wr_addr_i) < DEPTH)) begin
            bank_d.cells[wr_addr_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign rd_data_o = (int'(rd_addr_i) < DEPTH) ? bank_q.cells[rd_addr_i] : '0;

endmodule

// File: rtl/regwin_flatten.sv
module regwin_flatten
    import regwin_pkg::*;
#(
    parameter int NUM_ARCH  = 32,
    parameter int N_WIN     = 8,
    parameter int MAX_GL    = 4,
    parameter int NUM_MICRO = 8,
    parameter int DATA_W    = 16,
    localparam int GL_W     = $clog2(MAX_GL),
    localparam int CWP_W    = $clog2(N_WIN),
    localparam int IDX_W    = $clog2(3 * NUM_ARCH + NUM_MICRO + 1),
    localparam int PHYS_N   = MAX_GL * 8 + N_WIN * 16 + NUM_MICRO,
    localparam int PHYS_W   = $clog2(PHYS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GL_W-1:0]   gl_i,
    input  logic [CWP_W-1:0]  cwp_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [PHYS_W-1:0] rd_phys_o,
    output logic              rd_invalid_o,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam int MICRO_LO = MAX_GL * 8 + N_WIN * 16;

    logic [PHYS_W-1:0] wr_phys;
    logic              wr_bad;
    seg_e              rd_seg;
    seg_e              wr_seg;
    logic [DATA_W-1:0] bank_rd;

    regwin_map #(
        .NUM_ARCH(NUM_ARCH), .N_WIN(N_WIN), .MAX_GL(MAX_GL), .NUM_MICRO(NUM_MICRO),
        .GL_W(GL_W), .CWP_W(CWP_W), .IDX_W(IDX_W), .PHYS_W(PHYS_W)
    ) rd_map_i (
        .gl_i(gl_i), .cwp_i(cwp_i), .idx_i(rd_idx_i),
        .phys_o(rd_phys_o), .bad_o(rd_invalid_o), .seg_o(rd_seg)
    );

    regwin_map #(
        .NUM_ARCH(NUM_ARCH), .N_WIN(N_WIN), .MAX_GL(MAX_GL), .NUM_MICRO(NUM_MICRO),
        .GL_W(GL_W), .CWP_W(CWP_W), .IDX_W(IDX_W), .PHYS_W(PHYS_W)
    ) wr_map_i (
        .gl_i(gl_i), .cwp_i(cwp_i), .idx_i(wr_idx_i),
        .phys_o(wr_phys), .bad_o(wr_bad), .seg_o(wr_seg)
    );

    regwin_bank #(
        .DEPTH(PHYS_N), .DATA_W(DATA_W), .AW(PHYS_W)
    ) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i && !wr_bad), .wr_addr_i(wr_phys), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_phys_o), .rd_data_o(bank_rd)
    );

    assign rd_data_o = rd_invalid_o ? '0 : bank_rd;

    // R6: an illegal index reads as zero on both index and data
    a_r6_bad_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_invalid_o |-> (rd_phys_o == '0 && rd_data_o == '0));

    // R6: a legal index always lands inside the physical array
    a_r6_phys_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_invalid_o |-> (int'(rd_phys_o) < PHYS_N));

    // R3: microcode indices land in the region after the windows
    a_r3_micro_region: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_seg == SEG_MICRO) |-> (int'(rd_phys_o) >= MICRO_LO));

    // R7: a legal write is visible next cycle at the same physical location
    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_bad && !rd_invalid_o && rd_phys_o == wr_phys && wr_seg != SEG_BAD)
        |=> (!($stable(rd_phys_o) && !rd_invalid_o) || rd_data_o == $past(wr_data_i)));

    // R8: a write to an illegal index changes nothing that is read
    a_r8_bad_write_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_bad)
        |=> (!($stable(rd_phys_o) && $stable(rd_invalid_o)) || $stable(rd_data_o)));

endmodule

// File: tb/regwin_flatten_tb.sv
`timescale 1ns/1ps
module regwin_flatten_tb_top;

    localparam int A  = 32;
    localparam int NW = 8;
    localparam int MG = 4;
    localparam int NM = 8;
    localparam int PN = MG * 8 + NW * 16 + NM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  gl = '0;
    logic [2:0]  cwp = '0;
    logic [6:0]  rd_idx = '0;
    logic [7:0]  rd_phys;
    logic        rd_invalid;
    logic [15:0] rd_data;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic [15:0] exp_mem [PN];

    always #5 clk = ~clk;

    regwin_flatten dut_i (
        .clk(clk), .rst_n(rst_n), .gl_i(gl), .cwp_i(cwp),
        .rd_idx_i(rd_idx), .rd_phys_o(rd_phys), .rd_invalid_o(rd_invalid),
        .rd_data_o(rd_data), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data)
    );

    // Arithmetic reference for the index mapping
    function automatic void model(input int g, input int c, input int i,
                                  output int ph, output bit bad);
        int lr;
        int w;
        bad = 1'b0;
        ph  = 0;
        if (i >= 3 * A + NM) begin
            bad = 1'b1;
            return;
        end
        if (i < A) begin
            lr = i; w = c;
        end else if (i < A + NM) begin
            ph = i - A + MG * 8 + NW * 16;
            return;
        end else if (i < 2 * A + NM) begin
            lr = i - (A + NM); w = (c + NW - 1) % NW;
        end else begin
            lr = i - (2 * A + NM); w = (c + 1) % NW;
        end
        if (lr < 8) ph = lr + 8 * g;
        else        ph = MG * 8 + ((lr - 8) + 16 * (NW - w)) % (NW * 16);
    endfunction

    function automatic string tag_of(input int i);
        int lr;
        if (i >= 3 * A + NM) return "R6";
        if (i >= A && i < A + NM) return "R3";
        lr = (i < A) ? i : ((i < 2 * A + NM) ? i - (A + NM) : i - (2 * A + NM));
        if (lr < 8) return "R1";
        if (i < A) return "R2";
        if (i < 2 * A + NM) return "R4";
        return "R5";
    endfunction

    task automatic probe(input int g, input int c, input int i, input string dtag);
        int  ph;
        bit  bad;
        logic [15:0] ed;
        string t;
        @(negedge clk);
        gl = 2'(g); cwp = 3'(c); rd_idx = 7'(i);
        #2;
        model(g, c, i, ph, bad);
        t  = tag_of(i);
        ed = bad ? 16'h0 : exp_mem[ph];
        vectors++;
        if (rd_invalid !== bad) begin
            misses++;
            $display("FAIL %s invalid gl=%0d cwp=%0d idx=%0d got %0b exp %0b", t, g, c, i, rd_invalid, bad);
        end else if (rd_phys !== 8'(ph)) begin
            misses++;
            $display("FAIL %s phys gl=%0d cwp=%0d idx=%0d got %0d exp %0d", t, g, c, i, rd_phys, ph);
        end else if (rd_data !== ed) begin
            misses++;
            $display("FAIL %s data gl=%0d cwp=%0d idx=%0d got %h exp %h",
                     bad ? "R6" : dtag, g, c, i, rd_data, ed);
        end
    endtask

    task automatic sweep(input string dtag);
        for (int g = 0; g < MG; g++)
            for (int c = 0; c < NW; c++)
                for (int i = 0; i < 128; i++)
                    probe(g, c, i, dtag);
    endtask

    task automatic put(input int g, input int c, input int i, input logic [15:0] d);
        int ph;
        bit bad;
        @(negedge clk);
        gl = 2'(g); cwp = 3'(c); wr_idx = 7'(i); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model(g, c, i, ph, bad);
        if (!bad) exp_mem[ph] = d;
    endtask

    initial begin
        for (int p = 0; p < PN; p++) exp_mem[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset contents, full mapping sweep (R1 R2 R3 R4 R5 R6)
        sweep("R9");

        // R7: fill every location through globals, windows and microcode
        for (int g = 0; g < MG; g++)
            for (int i = 0; i < 8; i++) begin
                int ph; bit bad;
                model(g, 0, i, ph, bad);
                put(g, 0, i, 16'(ph * 37 + 5));
            end
        for (int c = 0; c < NW; c++)
            for (int i = 8; i < 24; i++) begin
                int ph; bit bad;
                model(0, c, i, ph, bad);
                put(0, c, i, 16'(ph * 37 + 5));
            end
        for (int i = A; i < A + NM; i++) begin
            int ph; bit bad;
            model(1, 3, i, ph, bad);
            put(1, 3, i, 16'(ph * 37 + 5));
        end
        // R7: overwrite through the alias ranges at the wrapping pointers
        put(2, 0, 2 * A + NM - 1, 16'hA5A0);
        put(3, 7, 3 * A + NM - 1, 16'h5A5B);
        put(1, 0, A + NM + 8, 16'h1234);
        put(0, 7, 2 * A + NM + 9, 16'h4321);
        sweep("R7");

        // R8: writes to illegal indices change nothing
        for (int i = 3 * A + NM; i < 128; i++) put(i % MG, i % NW, i, 16'hDEAD);
        sweep("R8");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, got hang exp finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule